// File: doc/BRIEF.md
# Eight-Line GPIO Controller with Interrupts

This block gives software control over eight general purpose pins through a small byte-wide register bus. Each pin can be an input or an output. The pad output value and the pad output enable come straight from registers. Pin data is reached through an address window. Bits [9:2] of the address form a per-pin selection mask, so a single store can change any chosen group of outputs and leave every other output alone. No read-modify-write sequence is needed.

Every pin can also raise an interrupt. The pin value is first brought into the clock domain through a synchroniser. The pin can then be watched in one of three ways:

- for a level of a chosen polarity;
- for one chosen edge;
- for both edges.

Edge events are held in a status bit until software clears them by writing a one. Level events are not held; they follow the pin. An enable register filters the raw status into a masked status. A single interrupt line is the OR of the masked bits.

Top module: `gpio_octet`

## Requirements
- R1: After reset, direction, output value, interrupt enable and all interrupt configuration registers are zero. So `pin_oe` is 0x00, `pin_out` is 0x00 and `irq` is low.
- R2: A write to offset 0x400 sets the direction register. Bit n = 1 makes pin n an output. `pin_oe` equals the register from the cycle after the write, and a read of 0x400 returns it.
- R3: A write to an address below 0x400 updates output bit n only when address bit (n+2) is set and direction bit n is 1. All other output bits keep their values.
- R4: A read below 0x400 returns, for each pin n whose address bit (n+2) is set, the output register bit if pin n is an output or the synchronised pin value if it is an input. Bits that are not selected read as zero.
- R5: A data write aimed at an input pin leaves that pin's output value unchanged. The value must be written again after the pin is switched to output.
- R6: Sense bit n = 1 (offset 0x404) puts pin n in level mode. There, raw status bit n (offset 0x414) is 1 while the synchronised pin equals event bit n (offset 0x40C), where 1 means high. The bit appears two clock edges after the pin changes and is never latched.
- R7: In edge mode with both-edges bit n (offset 0x408) clear, event bit n = 1 latches raw status on a rising edge and 0 latches it on a falling edge. The bit is set on the third clock edge after the pin changes.
- R8: With both-edges bit n set, rising and falling edges both latch raw status, whatever the event bit holds.
- R9: Masked status (offset 0x418) equals raw status AND the enable register (offset 0x410). `irq` is high exactly when any masked bit is 1.
- R10: Writing to offset 0x41C clears each latched edge status bit whose write-data bit is 1. Zero bits and level-mode bits are unaffected.
- R11: When an edge event and a clear write hit the same pin in the same cycle, the status bit stays set.
- R12: The sense, both-edges, event and enable registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` and state |
| pin_in | input | 8 | Pad input values, asynchronous |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables, 1 drives the pad |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes take effect on the clock edge that samples `bus_we`. `pin_oe` and `pin_out` are therefore checked half a cycle after that edge, and read data is checked combinationally a moment after the address settles.

A pin change reaches the synchronised value on the second edge. Level status is therefore expected after two edges. Edge status passes through one more register and is expected after three. The bench samples one edge early to confirm that the bit is still clear.

The same-cycle case lines the clear write up with the third edge after an edge on the pin. The interrupt output is combinational from status and enable, so it is checked together with the masked status read.

// File: rtl/gpio_octet_pkg.sv
package gpio_octet_pkg;
   localparam int ADDR_W   = 12;
   localparam int OFS_DIR  = 'h400;
   localparam int OFS_SNS  = 'h404;
   localparam int OFS_BOTH = 'h408;
   localparam int OFS_EVT  = 'h40C;
   localparam int OFS_IEN  = 'h410;
   localparam int OFS_RAW  = 'h414;
   localparam int OFS_MSK  = 'h418;
   localparam int OFS_CLR  = 'h41C;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_DATA, SEL_DIR, SEL_SNS, SEL_BOTH,
      SEL_EVT, SEL_IEN, SEL_RAW, SEL_MSK, SEL_CLR
   } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio_in_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_event.sv
module gpio_pin_event (
   input  logic clk,
   input  logic rst_n,
   input  logic cur,
   input  logic prev,
   input  logic lvl_mode,
   input  logic both,
   input  logic pol,
   input  logic clr,
   output logic raw
);
   logic rise, fall, edge_hit, lat_q;

   assign rise     = cur & ~prev;
   assign fall     = ~cur & prev;
   assign edge_hit = ~lvl_mode & (both ? (rise | fall) : (pol ? rise : fall));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lat_q <= 1'b0;
      else if (edge_hit) lat_q <= 1'b1;
      else if (clr)      lat_q <= 1'b0;
   end

   assign raw = lvl_mode ? (cur == pol) : lat_q;

   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !edge_hit) |=> !lat_q);

   p_edge_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |=> lat_q);
endmodule

// File: rtl/gpio_octet.sv
module gpio_octet
   import gpio_octet_pkg::*;
#(
   parameter int NPINS       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [NPINS-1:0]  bus_wdata,
   output logic [NPINS-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq
);
   localparam int WIN_LO = 2;
   localparam int WIN_HI = WIN_LO + NPINS - 1;

   generate
      if (NPINS < 1 || NPINS > 8) begin : g_bad_pins
         $error("gpio_octet: NPINS must be 1..8 to fit the data window");
      end
   endgenerate

   logic [NPINS-1:0] pin_s, pin_d;
   logic [NPINS-1:0] dir_q, out_q, sns_q, both_q, evt_q, ien_q;
   logic [NPINS-1:0] raw_st, msk_st, clr_vec, win_mask, pin_view;
   logic             in_data;
   reg_sel_e         sel;

   gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_d <= '0;
      else        pin_d <= pin_s;
   end

   assign in_data  = (bus_addr[ADDR_W-1:10] == '0);
   assign win_mask = bus_addr[WIN_HI:WIN_LO];

   always_comb begin
      sel = SEL_NONE;
      if (in_data)                              sel = SEL_DATA;
      else if (bus_addr == ADDR_W'(OFS_DIR))   sel = SEL_DIR;
      else if (bus_addr == ADDR_W'(OFS_SNS))   sel = SEL_SNS;
      else if (bus_addr == ADDR_W'(OFS_BOTH))  sel = SEL_BOTH;
      else if (bus_addr == ADDR_W'(OFS_EVT))   sel = SEL_EVT;
      else if (bus_addr == ADDR_W'(OFS_IEN))   sel = SEL_IEN;
      else if (bus_addr == ADDR_W'(OFS_RAW))   sel = SEL_RAW;
      else if (bus_addr == ADDR_W'(OFS_MSK))   sel = SEL_MSK;
      else if (bus_addr == ADDR_W'(OFS_CLR))   sel = SEL_CLR;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         sns_q  <= '0;
         both_q <= '0;
         evt_q  <= '0;
         ien_q  <= '0;
      end else if (bus_we) begin
         case (sel)
            SEL_DATA: out_q  <= (out_q & ~(win_mask & dir_q)) |
                                (bus_wdata & win_mask & dir_q);
            SEL_DIR:  dir_q  <= bus_wdata;
            SEL_SNS:  sns_q  <= bus_wdata;
            SEL_BOTH: both_q <= bus_wdata;
            SEL_EVT:  evt_q  <= bus_wdata;
            SEL_IEN:  ien_q  <= bus_wdata;
            default: ;
         endcase
      end
   end

   assign clr_vec = (bus_we && sel == SEL_CLR) ? bus_wdata : '0;

   generate
      for (genvar n = 0; n < NPINS; n++) begin : g_pin
         gpio_pin_event i_evt (
            .clk(clk), .rst_n(rst_n),
            .cur(pin_s[n]), .prev(pin_d[n]),
            .lvl_mode(sns_q[n]), .both(both_q[n]), .pol(evt_q[n]),
            .clr(clr_vec[n]), .raw(raw_st[n])
         );
      end
   endgenerate

   assign msk_st   = raw_st & ien_q;
   assign pin_view = (dir_q & out_q) | (~dir_q & pin_s);

   always_comb begin
      case (sel)
         SEL_DATA: bus_rdata = win_mask & pin_view;
         SEL_DIR:  bus_rdata = dir_q;
         SEL_SNS:  bus_rdata = sns_q;
         SEL_BOTH: bus_rdata = both_q;
         SEL_EVT:  bus_rdata = evt_q;
         SEL_IEN:  bus_rdata = ien_q;
         SEL_RAW:  bus_rdata = raw_st;
         SEL_MSK:  bus_rdata = msk_st;
         default:  bus_rdata = '0;
      endcase
   end

   assign pin_out = out_q;
   assign pin_oe  = dir_q;
   assign irq     = |msk_st;

   p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(OFS_DIR)) |=> (pin_oe == $past(bus_wdata)));

   p_input_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && in_data) |=> ((pin_out & ~pin_oe) == ($past(pin_out) & ~$past(pin_oe))));

   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq);
endmodule

// File: tb/test_gpio_octet.sv
module test_gpio_octet;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_out, pin_oe;
   logic        irq;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;
   int seed;
   logic [7:0] dir_m, out_m;

   gpio_octet i_gpio_octet (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   always #5 clk = ~clk;

   function automatic logic [7:0] exp_out(logic [7:0] o, logic [7:0] d,
                                          logic [7:0] m, logic [7:0] w);
      return (o & ~(m & d)) | (w & m & d);
   endfunction

   function automatic logic [7:0] exp_rd(logic [7:0] o, logic [7:0] d,
                                         logic [7:0] p, logic [7:0] m);
      return m & ((d & o) | (~d & p));
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      seed = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 pin_oe", pin_oe, 8'h00);
      chk("R1 pin_out", pin_out, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);
      rd(12'h410, r); chk("R1 enable", r, 8'h00);
      rd(12'h404, r); chk("R1 sense", r, 8'h00);

      // R5 directed: write to inputs ignored, must be rewritten after switch
      wr(12'h400, 8'h0F);
      wr(12'h3FC, 8'hFF);
      chk("R5 inputs untouched", pin_out, 8'h0F);
      wr(12'h400, 8'hFF);
      chk("R5 after switch", pin_out, 8'h0F);
      wr(12'h3FC, 8'hFF);
      chk("R5 rewrite", pin_out, 8'hFF);
      dir_m = 8'hFF; out_m = 8'hFF;

      // R2 R3 R4 random masked accesses
      for (int i = 0; i < 60; i++) begin
         logic [7:0] d, m, w, p, m2;
         d = 8'($urandom); m = 8'($urandom); w = 8'($urandom);
         p = 8'($urandom); m2 = 8'($urandom);
         pin_in = p;
         wr(12'h400, d);
         dir_m = d;
         chk("R2 pin_oe", pin_oe, d);
         wr({2'b00, m, 2'b00}, w);
         out_m = exp_out(out_m, dir_m, m, w);
         chk("R3 masked write", pin_out, out_m);
         rd({2'b00, m2, 2'b00}, r);
         chk("R4 masked read", r, exp_rd(out_m, dir_m, p, m2));
         rd(12'h400, r);
         chk("R2 readback", r, d);
      end

      // R12 config readback
      for (int i = 0; i < 4; i++) begin
         logic [7:0] v;
         v = 8'($urandom);
         wr(12'h404 + 12'(4 * i), v);
         rd(12'h404 + 12'(4 * i), r);
         chk("R12 readback", r, v);
      end

      // interrupt setup: quiet pins, then configure
      pin_in = 8'h00;
      wr(12'h410, 8'h00);
      repeat (4) @(negedge clk);
      wr(12'h404, 8'h03);   // pins 0,1 level
      wr(12'h408, 8'h30);   // pins 4,5 both edges
      wr(12'h40C, 8'h15);   // pin0 high, pin2 rising, pin4 event set (ignored)
      wr(12'h41C, 8'hFF);
      rd(12'h414, r); chk("R6 level-low pin1 active", r, 8'h02);

      // raise every pin, check timing of level and edge status
      pin_in = 8'hFF;
      @(negedge clk);
      rd(12'h414, r); chk("R6 not before two edges", r, 8'h02);
      @(negedge clk);
      rd(12'h414, r); chk("R6 level after two edges", r, 8'h01);
      @(negedge clk);
      rd(12'h414, r); chk("R7 R8 rising edges latched", r, 8'h35);
      rd(12'h418, r); chk("R9 masked with enable off", r, 8'h00);
      chk("R9 irq off", {7'd0, irq}, 8'h00);
      wr(12'h410, 8'h0F);
      rd(12'h418, r); chk("R9 masked", r, 8'h05);
      chk("R9 irq on", {7'd0, irq}, 8'h01);
      wr(12'h410, 8'h08);
      chk("R9 irq off for non-pending enable", {7'd0, irq}, 8'h00);

      // R10 clear of edge bits, level bit not cleared
      wr(12'h41C, 8'h3D);
      rd(12'h414, r); chk("R10 clear", r, 8'h01);

      // drop every pin
      pin_in = 8'h00;
      repeat (3) @(negedge clk);
      rd(12'h414, r); chk("R7 R8 falling edges latched", r, 8'hFA);
      wr(12'h41C, 8'h08);
      rd(12'h414, r); chk("R10 single bit clear", r, 8'hF2);
      wr(12'h41C, 8'hFF);
      rd(12'h414, r); chk("R10 clear all", r, 8'h02);

      // R11 edge and clear in the same cycle
      pin_in = 8'h04;
      repeat (2) @(negedge clk);
      wr(12'h41C, 8'h04);
      rd(12'h414, r); chk("R11 edge wins", r, 8'h06);
      wr(12'h41C, 8'h04);
      rd(12'h414, r); chk("R11 later clear", r, 8'h02);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule